// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block is the host-facing configuration store of a multi-function peripheral chip. The host reaches it through two adjacent byte addresses in I/O space. The lower address holds a pointer into a private space of 256 byte-wide registers. The upper address reads or writes the register that the pointer selects. The first 48 entries of that space are chip-wide. Entry 0x07 chooses a function unit. Entries 0x30 and above then belong to the chosen unit only. Each unit has an activation byte, two relocatable I/O base addresses, two interrupt routing pairs and two DMA channel selectors.

A key sequence written to the pointer address guards the window, so stray software cannot change the configuration. Two back-to-back writes of 0x87 open it, and a write of 0xaa closes it again. Each unit's activation byte and a per-pair "interrupt routed" flag leave the block as plain outputs for the function units to use. Base registers keep their unsupported address bits at zero. Writing all ones to a base register and reading it back therefore shows the decode mask.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the window is closed. While closed, any read at either window address returns 0xff, and writes to either address (other than key bytes to the pointer address) change nothing.
- R2: The window opens only after two consecutive pointer-address writes of 0x87. Any other write to the window between them restarts the sequence. The key writes do not alter the pointer, which reads 0x00 after reset.
- R3: While open, a pointer-address write of 0xaa closes the window, and later reads return 0xff.
- R4: While open, a pointer-address write stores the pointer, and a read of the pointer address returns it. Data-address accesses act on the register the pointer names.
- R5: Entry 0x07 stores a unit number and reads it back. Entries 0x30–0xff of each unit are separate storage, so writing one unit leaves the others unchanged.
- R6: Entry 0x30 is an 8-bit activation byte per unit. Unit d's byte appears on dev_en[8d+7:8d].
- R7: Entries 0x60/0x61 (high byte, low byte) and 0x62/0x63 form two 16-bit bases per unit. Bits outside the mask read as zero. For unit d and slot s, the mask is L & ~((1 << (3+d+s)) - 1), with L = 0x07ff for slot 0 and 0x0fff for slot 1. For example, unit 0 slot 0 gives 0x07f8.
- R8: Entries 0x70 and 0x72 hold a 4-bit interrupt number in bits 3:0, and bits 7:4 read as zero. A nonzero number sets irq_on[2d+p] for unit d and pair p. Zero clears it.
- R9: Entries 0x71 and 0x73 store a polarity in bit 0. Bit 1 is the trigger type and always reads 0 (edge). The other bits read as zero.
- R10: Entries 0x74 and 0x75 hold a 3-bit DMA channel in bits 2:0, and the upper bits read as zero.
- R11: Entries that are not implemented, and all unit entries while the unit number is NDEV or above, read 0x00. Writes to them have no effect.
- R12: Reset clears all activation, base, interrupt and DMA fields, sets the unit number and the pointer to 0, and closes the window.
- R13: Accesses at addresses outside the window are ignored, and io_rdata is 0x00 whenever no window read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; data returned combinationally |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| dev_en | output | NDEV*8 | Activation byte of every unit |
| irq_on | output | NDEV*2 | Interrupt pair routed (number nonzero), per unit and pair |

## Verification
A fault in the lock state shows at once. The next read of either window address returns 0xff when it should return live data, or the reverse. A corrupted pointer or unit number misdirects the very next data access, so the following read-back returns another entry's value or 0x00. A masking fault in a base register shows in the first all-ones write followed by a read-back. A fault in interrupt routing appears on irq_on one cycle after the write, and a fault in activation appears on dev_en one cycle after the write.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    localparam logic [7:0] KEY_OPEN  = 8'h87;
    localparam logic [7:0] KEY_SHUT  = 8'haa;
    localparam logic [7:0] REG_UNIT  = 8'h07;
    localparam logic [7:0] UNIT_LO   = 8'h30;
    localparam logic [7:0] REG_ACT   = 8'h30;
    localparam logic [7:0] REG_B0_HI = 8'h60;
    localparam logic [7:0] REG_B0_LO = 8'h61;
    localparam logic [7:0] REG_B1_HI = 8'h62;
    localparam logic [7:0] REG_B1_LO = 8'h63;
    localparam logic [7:0] REG_IQ0_N = 8'h70;
    localparam logic [7:0] REG_IQ0_C = 8'h71;
    localparam logic [7:0] REG_IQ1_N = 8'h72;
    localparam logic [7:0] REG_IQ1_C = 8'h73;
    localparam logic [7:0] REG_DMA0  = 8'h74;
    localparam logic [7:0] REG_DMA1  = 8'h75;

    typedef struct packed {
        logic [3:0] num;
        logic       pol;
    } irq_t;

    typedef struct packed {
        logic [7:0]       act;
        logic [1:0][15:0] base;
        irq_t [1:0]       irq;
        logic [1:0][2:0]  dma;
    } unit_t;

    // Decode mask of base slot `slot` of unit `dev`.
    function automatic logic [15:0] base_mask(input int dev, input int slot);
        logic [15:0] limit;
        logic [15:0] low;
        limit = (slot == 0) ? 16'h07ff : 16'h0fff;
        low   = (16'd1 << (3 + dev + slot)) - 16'd1;
        return limit & ~low;
    endfunction

endpackage

// File: rtl/cfgwin_lock.sv
module cfgwin_lock
    import cfgwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key,
    input  logic       other_wr,
    output logic       open
);
    lock_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            LK_SHUT: if (key_wr && key == KEY_OPEN) nxt = LK_HALF;
            LK_HALF: begin
                if (key_wr)        nxt = (key == KEY_OPEN) ? LK_OPEN : LK_SHUT;
                else if (other_wr) nxt = LK_SHUT;
            end
            LK_OPEN: if (key_wr && key == KEY_SHUT) nxt = LK_SHUT;
            default: nxt = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LK_SHUT;
        else     state <= nxt;
    end

    assign open = (state == LK_OPEN);
endmodule

// File: rtl/cfgwin_unit.sv
module cfgwin_unit
    import cfgwin_pkg::*;
#(
    parameter int DEV = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] act,
    output logic [1:0] irq_on
);
    localparam logic [1:0][15:0] MASKS = {base_mask(DEV, 1), base_mask(DEV, 0)};

    unit_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr) begin
            case (idx)
                REG_ACT:   st.act <= wdata;
                REG_B0_HI: st.base[0][15:8] <= wdata & MASKS[0][15:8];
                REG_B0_LO: st.base[0][7:0]  <= wdata & MASKS[0][7:0];
                REG_B1_HI: st.base[1][15:8] <= wdata & MASKS[1][15:8];
                REG_B1_LO: st.base[1][7:0]  <= wdata & MASKS[1][7:0];
                REG_IQ0_N: st.irq[0].num <= wdata[3:0];
                REG_IQ0_C: st.irq[0].pol <= wdata[0];
                REG_IQ1_N: st.irq[1].num <= wdata[3:0];
                REG_IQ1_C: st.irq[1].pol <= wdata[0];
                REG_DMA0:  st.dma[0] <= wdata[2:0];
                REG_DMA1:  st.dma[1] <= wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            REG_ACT:   rdata = st.act;
            REG_B0_HI: rdata = st.base[0][15:8];
            REG_B0_LO: rdata = st.base[0][7:0];
            REG_B1_HI: rdata = st.base[1][15:8];
            REG_B1_LO: rdata = st.base[1][7:0];
            REG_IQ0_N: rdata = {4'h0, st.irq[0].num};
            REG_IQ0_C: rdata = {6'd0, 1'b0, st.irq[0].pol};
            REG_IQ1_N: rdata = {4'h0, st.irq[1].num};
            REG_IQ1_C: rdata = {6'd0, 1'b0, st.irq[1].pol};
            REG_DMA0:  rdata = {5'd0, st.dma[0]};
            REG_DMA1:  rdata = {5'd0, st.dma[1]};
            default:   rdata = 8'h00;
        endcase
    end

    assign act = st.act;

    for (genvar p = 0; p < 2; p++) begin : g_irq
        assign irq_on[p] = (st.irq[p].num != 4'h0);
    end
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h002e,
    parameter int          NDEV      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [NDEV*8-1:0] dev_en,
    output logic [NDEV*2-1:0] irq_on
);
    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;
    localparam logic [7:0]  NDEV_B    = 8'(NDEV);

    logic       hit_idx, hit_dat, win_open;
    logic [7:0] cur_idx, cur_ldn;
    logic       ldn_ok, in_unit;
    logic [7:0] unit_rd [NDEV];
    logic [7:0] sel_rd;

    assign hit_idx = (io_addr == BASE_ADDR);
    assign hit_dat = (io_addr == DATA_ADDR);
    assign ldn_ok  = (cur_ldn < NDEV_B);
    assign in_unit = (cur_idx >= UNIT_LO);

    cfgwin_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (io_wr & hit_idx),
        .key      (io_wdata),
        .other_wr (io_wr & hit_dat),
        .open     (win_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= 8'h00;
            cur_ldn <= 8'h00;
        end else if (win_open && io_wr) begin
            if (hit_idx && io_wdata != KEY_SHUT) cur_idx <= io_wdata;
            if (hit_dat && cur_idx == REG_UNIT)  cur_ldn <= io_wdata;
        end
    end

    for (genvar d = 0; d < NDEV; d++) begin : g_unit
        logic wr_d;
        assign wr_d = win_open & io_wr & hit_dat & in_unit & ldn_ok
                    & (cur_ldn == 8'(d));
        cfgwin_unit #(.DEV(d)) u_unit (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_d),
            .idx    (cur_idx),
            .wdata  (io_wdata),
            .rdata  (unit_rd[d]),
            .act    (dev_en[d*8 +: 8]),
            .irq_on (irq_on[d*2 +: 2])
        );
    end

    always_comb begin
        sel_rd = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (cur_ldn == 8'(d)) sel_rd = sel_rd | unit_rd[d];
        end
    end

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd && (hit_idx || hit_dat)) begin
            if (!win_open)         io_rdata = 8'hff;
            else if (hit_idx)      io_rdata = cur_idx;
            else if (cur_idx == REG_UNIT) io_rdata = cur_ldn;
            else if (in_unit)      io_rdata = sel_rd;
            else                   io_rdata = 8'h00;
        end
    end
endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
    parameter logic [15:0] BASE_ADDR = 16'h002e,
    parameter int          NDEV      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [NDEV*8-1:0] dev_en,
    input logic              win_open,
    input logic [7:0]        cur_idx,
    input logic [7:0]        cur_ldn
);
    logic in_win;
    assign in_win = (io_addr == BASE_ADDR) || (io_addr == BASE_ADDR + 16'd1);

    assert_locked_ff_R1: assert property (@(posedge clk) disable iff (rst)
        (io_rd && in_win && !win_open) |-> io_rdata == 8'hff);

    assert_two_keys_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(io_wr && io_addr == BASE_ADDR && io_wdata == 8'h87));

    assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
        (win_open && io_wr && io_addr == BASE_ADDR && io_wdata == 8'haa) |=> !win_open);

    assert_unit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(cur_ldn));

    assert_act_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(dev_en));

    assert_edge_type_R9: assert property (@(posedge clk) disable iff (rst)
        (io_rd && win_open && io_addr == BASE_ADDR + 16'd1
         && (cur_idx == 8'h71 || cur_idx == 8'h73)) |-> io_rdata[1] == 1'b0);

    assert_foreign_zero_R13: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && in_win) |-> io_rdata == 8'h00);
endmodule

bind cfgwin_top cfgwin_checker #(.BASE_ADDR(BASE_ADDR), .NDEV(NDEV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .dev_en   (dev_en),
    .win_open (win_open),
    .cur_idx  (cur_idx),
    .cur_ldn  (cur_ldn)
);

// File: tb/cfgwin_top_bench.sv
module cfgwin_top_bench;
    localparam int          NDEV = 4;
    localparam logic [15:0] PI   = 16'h002e;
    localparam logic [15:0] PD   = 16'h002f;
    localparam int          NV   = 51;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       io_addr = 16'h0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = 8'h0;
    logic [7:0]        io_rdata;
    logic [NDEV*8-1:0] dev_en;
    logic [NDEV*2-1:0] irq_on;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgwin_top #(.BASE_ADDR(PI), .NDEV(NDEV)) u_cfgwin_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en), .irq_on(irq_on)
    );

    // entry: {read, data_port, wdata, expected, req}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h00, 8'hff, 4'd1},  // R1 closed read
        {1'b0, 1'b1, 8'h55, 8'h00, 4'd1},  // R1 ignored data write
        {1'b0, 1'b0, 8'h87, 8'h00, 4'd2},
        {1'b0, 1'b0, 8'h01, 8'h00, 4'd2},  // R2 broken sequence
        {1'b0, 1'b0, 8'h87, 8'h00, 4'd2},
        {1'b1, 1'b0, 8'h00, 8'hff, 4'd2},  // R2 still closed
        {1'b0, 1'b0, 8'h87, 8'h00, 4'd2},
        {1'b1, 1'b0, 8'h00, 8'h00, 4'd4},  // R4 pointer untouched by keys
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'h01, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h01, 4'd5},  // R5 unit number read back
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd6},
        {1'b0, 1'b1, 8'ha5, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'ha5, 4'd6},  // R6 activation byte
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'h00, 8'h00, 4'd5},
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd5},  // R5 unit 0 separate
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd7},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'h07, 4'd7},  // R7 slot0 high
        {1'b0, 1'b0, 8'h61, 8'h00, 4'd7},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'hf8, 4'd7},  // R7 slot0 low
        {1'b0, 1'b0, 8'h62, 8'h00, 4'd7},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'h0f, 4'd7},  // R7 slot1 high
        {1'b0, 1'b0, 8'h63, 8'h00, 4'd7},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'hf0, 4'd7},  // R7 slot1 low
        {1'b0, 1'b0, 8'h70, 8'h00, 4'd8},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd8},
        {1'b1, 1'b1, 8'h00, 8'h0f, 4'd8},  // R8 number width
        {1'b0, 1'b0, 8'h71, 8'h00, 4'd9},
        {1'b0, 1'b1, 8'h03, 8'h00, 4'd9},
        {1'b1, 1'b1, 8'h00, 8'h01, 4'd9},  // R9 type reads edge
        {1'b0, 1'b0, 8'h74, 8'h00, 4'd10},
        {1'b0, 1'b1, 8'hff, 8'h00, 4'd10},
        {1'b1, 1'b1, 8'h00, 8'h07, 4'd10}, // R10 DMA width
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'h05, 8'h00, 4'd11},
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'h11, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd11}, // R11 absent unit
        {1'b0, 1'b0, 8'h20, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd11}, // R11 unimplemented global
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h05, 4'd5},  // R5 out-of-range number kept
        {1'b0, 1'b0, 8'haa, 8'h00, 4'd3},
        {1'b1, 1'b0, 8'h00, 8'hff, 4'd3},  // R3 relocked
        {1'b0, 1'b1, 8'h00, 8'h00, 4'd1}   // R1 closed write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, {24'd0, io_rdata}, {24'd0, exp});
        io_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(PI, 8'h87);
        wr(PI, 8'h87);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12", {16'd0, dev_en}, 32'd0);
        check("R12", {24'd0, irq_on}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            if (v[21]) rd(v[20] ? PD : PI, v[11:4], $sformatf("R%0d", v[3:0]));
            else       wr(v[20] ? PD : PI, v[19:12]);
        end

        // R6: unit 1 activation on its output slice, unit 0 clear
        check("R6", {16'd0, dev_en}, {16'd0, 16'ha500});
        // R8: unit 0 pair 0 routed
        check("R8", {24'd0, irq_on}, 32'h1);

        // R1: closed-window data write left unit number at 5
        unlock();
        wr(PI, 8'h07);
        rd(PD, 8'h05, "R1");
        wr(PD, 8'h00);
        wr(PI, 8'h70);
        wr(PD, 8'h00);
        check("R8", {24'd0, irq_on}, 32'h0);
        wr(PI, 8'h72);
        wr(PD, 8'h09);
        rd(PD, 8'h09, "R8");
        check("R8", {24'd0, irq_on}, 32'h2);

        // R4: pointer readback
        wr(PI, 8'h75);
        rd(PI, 8'h75, "R4");
        wr(PD, 8'hfe);
        rd(PD, 8'h06, "R10");

        // R13: foreign address
        rd(16'h0080, 8'h00, "R13");
        wr(16'h0080, 8'h33);
        rd(PD, 8'h06, "R13");
        rd(PI, 8'h75, "R13");

        // R2: data write between keys restarts the sequence
        wr(PI, 8'haa);
        wr(PI, 8'h87);
        wr(PD, 8'h00);
        wr(PI, 8'h87);
        rd(PI, 8'hff, "R2");

        // R12: reset values
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12", {16'd0, dev_en}, 32'd0);
        check("R12", {24'd0, irq_on}, 32'd0);
        rd(PI, 8'hff, "R12");
        unlock();
        rd(PI, 8'h00, "R12");
        wr(PI, 8'h07);
        rd(PD, 8'h00, "R12");
        wr(PI, 8'h60);
        rd(PD, 8'h00, "R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule